// File: doc/BRIEF.md
# Immediate Prefix Operand Extender

This block builds the 16-bit immediate operand used by each instruction of a small 16-bit RISC core. It also adds that operand to a base register value to give a load/store effective address. Most instructions carry only a 4-bit immediate field in bits [3:0]. The block widens that field in one of three ways, chosen by a mode input: sign-extended for arithmetic and logic, zero-extended for byte offsets, or zero-extended and doubled for word offsets.

A dedicated prefix opcode lets software form a full 16-bit constant from two consecutive instructions. When the instruction that retired just before the current one was a prefix, the block ignores the mode. It forms the operand from the low twelve bits of that earlier instruction word, placed above the current 4-bit field.

The block keeps two pieces of state: a one-bit prefix-pending flag and a copy of the last retired instruction word. Both change only on cycles where the retire strobe is high. The immediate and address outputs are combinational from the current instruction, the mode, the base value and this state.

Top module: `imx_operand_top`

## Requirements
- R1: After reset the prefix-pending flag is clear and the stored previous instruction is zero, so the first instruction's immediate follows its mode with no prefix applied.
- R2: An instruction whose opcode bits [15:12] equal 4'hD is a prefix; retiring it (retire_i high at a clock edge) makes the prefix pending for the following instruction.
- R3: Retiring any instruction whose bits [15:12] differ from 4'hD clears the pending prefix.
- R4: On cycles with retire_i low, neither the pending flag nor the stored previous instruction changes.
- R5: While a prefix is pending, imm_o equals {prev[11:0], insn_i[3:0]} for every mode value.
- R6: With no prefix pending and mode_i of 2'b00 or 2'b11 (arithmetic), imm_o is insn_i[3:0] sign-extended to 16 bits.
- R7: With no prefix pending and mode_i of 2'b10 (byte offset), imm_o is insn_i[3:0] zero-extended.
- R8: With no prefix pending and mode_i of 2'b01 (word offset), imm_o is insn_i[3:0] zero-extended and multiplied by two.
- R9: ea_o equals base_i plus imm_o, with the sum kept to its low 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | High when insn_i retires at this edge |
| insn_i | input | 16 | Current instruction word |
| mode_i | input | 2 | Extension mode: 00/11 arithmetic, 01 word offset, 10 byte offset |
| base_i | input | 16 | Base register value for the effective address |
| imm_o | output | 16 | Selected immediate operand |
| ea_o | output | 16 | base_i + imm_o, modulo 2^16 |

## Verification
The bench holds a prefix across stalled cycles with retire low. A design that updated its state without the strobe would lose the prefix, or would take it from a stalled instruction. It places a prefix directly after another prefix, which checks that the second prefix both uses the first and re-arms the flag, and it sends a prefix of 16'hDFFF with base 16'hFFFF. This shows whether the payload is truncated above bit 15 and whether the address wraps. Field values 4'h7 and 4'h8 at the sign boundary catch sign extension from the wrong bit. A word offset of 4'hF checks that the doubled value reaches bit 4 and does not spill into bit 5.

// File: rtl/imx_pkg.sv
package imx_pkg;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = 4;
  localparam int OPC_W   = 4;
  localparam int PAY_W   = WORD_W - FIELD_W;
  localparam logic [OPC_W-1:0] PREFIX_OPC = 4'hD;

  typedef enum logic [1:0] {
    MODE_ARITH     = 2'b00,
    MODE_WORD      = 2'b01,
    MODE_BYTE      = 2'b10,
    MODE_ARITH_ALT = 2'b11
  } ext_mode_e;

  function automatic logic [WORD_W-1:0] sext_field(input logic [FIELD_W-1:0] f);
    return {{(WORD_W-FIELD_W){f[FIELD_W-1]}}, f};
  endfunction

  function automatic logic [WORD_W-1:0] zext_field(input logic [FIELD_W-1:0] f);
    return {{(WORD_W-FIELD_W){1'b0}}, f};
  endfunction

  function automatic logic [WORD_W-1:0] word_field(input logic [FIELD_W-1:0] f);
    return {{(WORD_W-FIELD_W-1){1'b0}}, f, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] join_prefix(input logic [WORD_W-1:0] prev,
                                                    input logic [FIELD_W-1:0] f);
    return {prev[PAY_W-1:0], f};
  endfunction
endpackage

// File: rtl/imx_prefix_track.sv
module imx_prefix_track
  import imx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic [WORD_W-1:0] insn_i,
  output logic              pfx_valid_o,
  output logic [WORD_W-1:0] prev_insn_o
);
  logic              is_pfx_op;
  logic              pfx_q;
  logic [WORD_W-1:0] prev_q;

  assign is_pfx_op = (insn_i[WORD_W-1 -: OPC_W] == PREFIX_OPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q  <= 1'b0;
      prev_q <= '0;
    end else if (retire_i) begin
      pfx_q  <= is_pfx_op;
      prev_q <= insn_i;
    end
  end

  assign pfx_valid_o = pfx_q;
  assign prev_insn_o = prev_q;

  assert_pfx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && is_pfx_op) |=> pfx_q);
  assert_pfx_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !is_pfx_op) |=> !pfx_q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> ($stable(pfx_q) && $stable(prev_q)));
endmodule

// File: rtl/imx_extend.sv
module imx_extend
  import imx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] insn_i,
  input  logic [WORD_W-1:0] prev_i,
  input  logic              pfx_i,
  input  logic [1:0]        mode_i,
  output logic [WORD_W-1:0] imm_o
);
  logic [FIELD_W-1:0] field;
  logic [WORD_W-1:0]  short_imm;
  ext_mode_e          mode;

  assign field = insn_i[FIELD_W-1:0];
  assign mode  = ext_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_WORD:                short_imm = word_field(field);
      MODE_BYTE:                short_imm = zext_field(field);
      MODE_ARITH, MODE_ARITH_ALT: short_imm = sext_field(field);
      default:                  short_imm = sext_field(field);
    endcase
  end

  assign imm_o = pfx_i ? join_prefix(prev_i, field) : short_imm;

  assert_pfx_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_i |-> (imm_o[FIELD_W-1:0] == insn_i[FIELD_W-1:0]));
  assert_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && (mode_i == 2'b00 || mode_i == 2'b11)) |->
      ($countones(imm_o[WORD_W-1:FIELD_W-1]) == 0 ||
       $countones(imm_o[WORD_W-1:FIELD_W-1]) == WORD_W-FIELD_W+1));
  assert_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && mode_i == 2'b10) |-> (imm_o[WORD_W-1:FIELD_W] == '0));
  assert_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && mode_i == 2'b01) |-> (imm_o[0] == 1'b0 && imm_o[WORD_W-1:FIELD_W+1] == '0));
endmodule

// File: rtl/imx_ea_add.sv
module imx_ea_add
  import imx_pkg::*;
(
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] imm_i,
  output logic [WORD_W-1:0] ea_o
);
  logic [WORD_W:0] full_sum;
  assign full_sum = {1'b0, base_i} + {1'b0, imm_i};
  assign ea_o     = full_sum[WORD_W-1:0];
endmodule

// File: rtl/imx_operand_top.sv
module imx_operand_top
  import imx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retire_i,
  input  logic [15:0] insn_i,
  input  logic [1:0]  mode_i,
  input  logic [15:0] base_i,
  output logic [15:0] imm_o,
  output logic [15:0] ea_o
);
  logic              pfx_valid;
  logic [WORD_W-1:0] prev_insn;

  imx_prefix_track u_track (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .insn_i(insn_i),
    .pfx_valid_o(pfx_valid), .prev_insn_o(prev_insn)
  );

  imx_extend u_ext (
    .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .prev_i(prev_insn),
    .pfx_i(pfx_valid), .mode_i(mode_i), .imm_o(imm_o)
  );

  imx_ea_add u_add (
    .base_i(base_i), .imm_i(imm_o), .ea_o(ea_o)
  );

  assert_ea_nopfx_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_valid && mode_i == 2'b10) |-> (ea_o[15:4] == base_i[15:4] ||
                                         ea_o[15:4] == base_i[15:4] + 12'd1));
endmodule

// File: tb/imx_operand_top_tb_top.sv
`timescale 1ns/1ps
module imx_operand_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 1'b0;
  logic [15:0] insn_i = '0;
  logic [1:0]  mode_i = '0;
  logic [15:0] base_i = '0;
  logic [15:0] imm_o, ea_o;

  int checks = 0;
  int errors = 0;
  bit m_pfx = 1'b0;
  logic [15:0] m_prev = '0;

  always #2 clk = ~clk;

  imx_operand_top dut_i (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .insn_i(insn_i),
    .mode_i(mode_i), .base_i(base_i), .imm_o(imm_o), .ea_o(ea_o)
  );

  function automatic logic [15:0] exp_imm(bit pfx, logic [15:0] prev,
                                          logic [15:0] ins, logic [1:0] md);
    int v;
    v = int'(ins & 16'h000F);
    if (pfx) return 16'((prev * 16) + v);
    if (md == 2'b10) return 16'(v);
    if (md == 2'b01) return 16'(v * 2);
    if (v >= 8) return 16'(v - 16);
    return 16'(v);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one instruction slot: drive after negedge, check, then let posedge update
  task automatic slot(logic [15:0] ins, logic [1:0] md, logic [15:0] b,
                      bit ret, string req);
    logic [15:0] ei;
    @(negedge clk);
    insn_i = ins; mode_i = md; base_i = b; retire_i = ret;
    #1;
    ei = exp_imm(m_pfx, m_prev, ins, md);
    check(req, imm_o, ei);
    check("R9", ea_o, 16'(b + ei));
    if (ret) begin
      m_pfx  = (ins[15:12] == 4'hD);
      m_prev = ins;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, arithmetic negative and word mode
    slot(16'h1238, 2'b00, 16'h0100, 1'b0, "R1");
    slot(16'h1237, 2'b01, 16'h0100, 1'b1, "R1");
    // R6 sign boundary, alternate encoding
    slot(16'h0008, 2'b11, 16'h0000, 1'b1, "R6");
    slot(16'h0007, 2'b00, 16'h0000, 1'b1, "R6");
    // R7 and R8 extremes
    slot(16'h000F, 2'b10, 16'h00F0, 1'b1, "R7");
    slot(16'h000F, 2'b01, 16'h0010, 1'b1, "R8");
    // R2/R5: prefix, stalled, then used in each mode
    slot(16'hDABC, 2'b00, 16'h0000, 1'b1, "R2");
    slot(16'h5555, 2'b10, 16'h0000, 1'b0, "R4");
    slot(16'h3333, 2'b01, 16'h0000, 1'b0, "R4");
    slot(16'h0009, 2'b10, 16'h1000, 1'b1, "R5");
    // R3: cleared after non-prefix
    slot(16'h0009, 2'b00, 16'h0000, 1'b1, "R3");
    // back-to-back prefixes, wrap of ea
    slot(16'hDFFF, 2'b00, 16'h0000, 1'b1, "R2");
    slot(16'hD123, 2'b01, 16'hFFFF, 1'b1, "R5");
    slot(16'h000E, 2'b00, 16'hFFFF, 1'b1, "R5");
    slot(16'h000E, 2'b00, 16'hFFFF, 1'b1, "R3");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] ins;
      ins = 16'($urandom);
      if ($urandom_range(0, 3) == 0) ins[15:12] = 4'hD;
      slot(ins, 2'($urandom), 16'($urandom), ($urandom_range(0, 4) != 0),
           m_pfx ? "R5" : "R6");
    end
    // reset mid-prefix clears state
    slot(16'hD777, 2'b00, 16'h0000, 1'b1, "R2");
    @(negedge clk); rst_n = 1'b0; retire_i = 1'b0;
    m_pfx = 1'b0; m_prev = '0;
    @(negedge clk); rst_n = 1'b1;
    slot(16'h000C, 2'b10, 16'h0002, 1'b0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule